// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Encoded Wait States

This block runs one read or one write at a time on a 16-bit asynchronous SRAM-style bus, for example one side of a shared dual-port memory. A host presents a request on a valid/acknowledge port. The request carries a direction, a 15-bit word address, write data and a two-bit byte mask. The controller then drives an active-low chip select, an output enable, a write enable, the address and two active-low byte-lane enables. During writes it also drives the data bus, with a separate drive-enable that stands in for the tri-state buffer.

A 16-bit configuration half-word sets the timing. Bits [7:4] hold the read delay code, bits [11:8] the write delay code and bits [14:12] the recovery code. The remaining bits (memory type [2:0], bus width [3], buffer select [15]) do not affect timing. Each 4-bit delay code maps to a cycle count: codes 0 to 11 map to themselves, and codes 12, 13, 14 and 15 map to 13, 15, 20 and 30. A read window lasts that count plus two cycles. A write window lasts the write count plus one cycle. After every access the bus rests with chip select high for twice the recovery code plus one cycle. A request that arrives during that rest waits and starts as soon as the rest is over.

Top module: `sram_wait_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n and mem_lb_n are 1, and mem_dq_oe and req_ack are 0.
- R2: A delay code c in 0..11 decodes to c cycles. Codes 12, 13, 14 and 15 decode to 13, 15, 20 and 30 cycles.
- R3: A read (req_write=0) holds mem_cs_n and mem_oe_n at 0 for exactly decode(cfg[7:4])+2 consecutive cycles, with mem_we_n at 1 throughout.
- R4: A write (req_write=1) holds mem_cs_n and mem_we_n at 0 for exactly decode(cfg[11:8])+1 consecutive cycles, with mem_oe_n at 1 throughout.
- R5: req_ack is high for exactly one cycle, the last cycle of the chip-select window. On a read, rsp_rdata equals mem_dq_in in that cycle. rsp_rdata then holds that value until the next read completes.
- R6: mem_dq_oe is 1 exactly during a write window, and mem_dq_out then equals the request's write data. It is 0 during reads and idle.
- R7: Within a window, mem_ub_n = ~req_mask[1] and mem_lb_n = ~req_mask[0]; a mask bit of 1 enables its lane. Outside a window both are 1.
- R8: After each window, mem_cs_n stays 1 for exactly 2*cfg[14:12]+1 cycles when a request is already pending, and for at least that many otherwise.
- R9: From idle, a request seen high at a clock edge starts its window in the cycle right after that edge.
- R10: The configuration is sampled when a window starts. Changing it during the window or the following recovery does not alter that window's length or its recovery.
- R11: mem_addr equals the request address and stays constant for the whole window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 16 | Timing configuration half-word |
| req_valid | input | 1 | Host request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lane enables, bit 1 upper, bit 0 lower |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 15 | Memory address |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_dq_out | output | 16 | Data driven to the bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Data read from the bus |

## Verification
Take a request first seen at edge p, with window length L and recovery length R. The window fills the cycles after edges p through p+L-1, the acknowledge falls in the cycle after edge p+L-1, and no new window may start before edge p+L+R. The bench's behavioural model predicts the start edge from these counts, using the configuration as it stands when the request is presented. It then compares every output at each falling edge from the moment the request is presented until its acknowledge. Idle stretches are compared the same way, including the held read data.

// File: rtl/sram_wait_pkg.sv
`timescale 1ns/1ps
package sram_wait_pkg;

    localparam int CFG_W      = 16;
    localparam int RD_CODE_LO = 4;
    localparam int WR_CODE_LO = 8;
    localparam int REC_CODE_LO = 12;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_RECOVER = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [3:0] rd_code;
        logic [3:0] wr_code;
        logic [2:0] rec_code;
    } timing_codes_t;

    function automatic timing_codes_t split_cfg(logic [CFG_W-1:0] cfg);
        timing_codes_t t;
        t.rd_code  = cfg[RD_CODE_LO +: 4];
        t.wr_code  = cfg[WR_CODE_LO +: 4];
        t.rec_code = cfg[REC_CODE_LO +: 3];
        return t;
    endfunction

    function automatic logic [4:0] decode_delay(logic [3:0] code);
        logic [4:0] cyc;
        case (code)
            4'd12:   cyc = 5'd13;
            4'd13:   cyc = 5'd15;
            4'd14:   cyc = 5'd20;
            4'd15:   cyc = 5'd30;
            default: cyc = {1'b0, code};
        endcase
        return cyc;
    endfunction

endpackage

// File: rtl/swc_timing_decode.sv
`timescale 1ns/1ps
module swc_timing_decode
    import sram_wait_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [CFG_W-1:0] cfg_word,
    output logic [CNT_W-1:0] rd_len,
    output logic [CNT_W-1:0] wr_len,
    output logic [CNT_W-1:0] rec_len
);
    timing_codes_t codes;

    always_comb begin
        codes   = split_cfg(cfg_word);
        rd_len  = CNT_W'(decode_delay(codes.rd_code)) + CNT_W'(2);
        wr_len  = CNT_W'(decode_delay(codes.wr_code)) + CNT_W'(1);
        rec_len = CNT_W'({codes.rec_code, 1'b1});
    end
endmodule

// File: rtl/swc_sequencer.sv
`timescale 1ns/1ps
module swc_sequencer
    import sram_wait_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 6,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    input  logic [CNT_W-1:0]  rd_len,
    input  logic [CNT_W-1:0]  wr_len,
    input  logic [CNT_W-1:0]  rec_len,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              req_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  lane_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);
    seq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  win_len_q;
    logic [CNT_W-1:0]  rec_len_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic [DATA_W-1:0] rdata_q;

    logic in_win, win_last, rec_last, start;

    assign in_win   = (state_q == ST_ACCESS);
    assign win_last = in_win && (cnt_q == win_len_q - CNT_W'(1));
    assign rec_last = (state_q == ST_RECOVER) && (cnt_q == rec_len_q - CNT_W'(1));
    assign start    = req_valid && ((state_q == ST_IDLE) || rec_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            win_len_q <= '0;
            rec_len_q <= '0;
            wr_q      <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            mask_q    <= '0;
            rdata_q   <= '0;
        end else begin
            if (start) begin
                state_q   <= ST_ACCESS;
                cnt_q     <= '0;
                win_len_q <= req_write ? wr_len : rd_len;
                rec_len_q <= rec_len;
                wr_q      <= req_write;
                addr_q    <= req_addr;
                wdata_q   <= req_wdata;
                mask_q    <= req_mask;
            end else if (win_last) begin
                state_q <= ST_RECOVER;
                cnt_q   <= '0;
            end else if (rec_last) begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
            end else if (state_q != ST_IDLE) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (win_last && !wr_q) begin
                rdata_q <= mem_dq_in;
            end
        end
    end

    assign req_ack    = win_last;
    assign rsp_rdata  = (win_last && !wr_q) ? mem_dq_in : rdata_q;
    assign mem_cs_n   = !in_win;
    assign mem_oe_n   = !(in_win && !wr_q);
    assign mem_we_n   = !(in_win && wr_q);
    assign mem_dq_oe  = in_win && wr_q;
    assign mem_dq_out = wdata_q;
    assign mem_addr   = addr_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_n[g] = !(in_win && mask_q[g]);
    end

    // Checker state: idle cycles since the last window and the gap it demands
    logic [7:0]       chk_gap_q;
    logic [CNT_W-1:0] chk_need_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_gap_q  <= '1;
            chk_need_q <= '0;
        end else begin
            if (!mem_cs_n) chk_gap_q <= '0;
            else if (chk_gap_q != '1) chk_gap_q <= chk_gap_q + 8'd1;
            if (req_ack) chk_need_q <= rec_len_q;
        end
    end

    // R3 R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    // R6
    drive_window_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_cs_n && !mem_we_n));

    // R5
    ack_ends_window_chk: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> (mem_cs_n && !req_ack));

    // R5
    ack_inside_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_cs_n) |-> $past(req_ack));

    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // R8
    recovery_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_cs_n) |-> (chk_gap_q >= 8'(chk_need_q)));
endmodule

// File: rtl/sram_wait_ctrl.sv
`timescale 1ns/1ps
module sram_wait_ctrl
    import sram_wait_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8,
    localparam int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              req_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    logic [CNT_W-1:0] rd_len, wr_len, rec_len;
    logic [LANES-1:0] lane_n;

    swc_timing_decode #(.CNT_W(CNT_W)) u_dec (
        .cfg_word (cfg_word),
        .rd_len   (rd_len),
        .wr_len   (wr_len),
        .rec_len  (rec_len)
    );

    swc_sequencer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_mask   (req_mask),
        .rd_len     (rd_len),
        .wr_len     (wr_len),
        .rec_len    (rec_len),
        .mem_dq_in  (mem_dq_in),
        .req_ack    (req_ack),
        .rsp_rdata  (rsp_rdata),
        .mem_cs_n   (mem_cs_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_addr   (mem_addr),
        .lane_n     (lane_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );

    assign mem_ub_n = lane_n[LANES-1];
    assign mem_lb_n = lane_n[0];
endmodule

// File: tb/sim_sram_wait_ctrl.sv
`timescale 1ns/1ps
module sim_sram_wait_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_word = 16'h0000;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ack;
    logic [15:0] rsp_rdata;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [14:0] mem_addr;
    logic [15:0] mem_dq_out, mem_dq_in;

    always #2.5 clk = ~clk;

    assign mem_dq_in = mem_oe_n ? 16'h0000 : ({1'b0, mem_addr} ^ 16'hC35A);

    sram_wait_ctrl u0 (
        .clk(clk), .rst(rst), .cfg_word(cfg_word),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .req_ack(req_ack),
        .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_ub_n(mem_ub_n),
        .mem_lb_n(mem_lb_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int earliest = 0;
    logic [15:0] last_rd = 16'h0000;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // R2: reference decode of a delay code
    function automatic int ref_delay(int code);
        if (code <= 11) return code;
        if (code == 12) return 13;
        if (code == 13) return 15;
        if (code == 14) return 20;
        return 30;
    endfunction

    function automatic logic [15:0] mk_cfg(int rd, int wr, int rec, logic [3:0] misc);
        logic [15:0] c;
        c = 16'h0000;
        c[7:4] = 4'(rd);
        c[11:8] = 4'(wr);
        c[14:12] = 3'(rec);
        c[15] = misc[3];
        c[3:0] = {misc[2], misc[2:0]};
        return c;
    endfunction

    task automatic check_quiet(string tag);
        chk({tag, " cs_n"}, 32'(mem_cs_n), 1);
        chk({tag, " oe_n"}, 32'(mem_oe_n), 1);
        chk({tag, " we_n"}, 32'(mem_we_n), 1);
        chk({tag, " ub_n"}, 32'(mem_ub_n), 1);
        chk({tag, " lb_n"}, 32'(mem_lb_n), 1);
        chk({tag, " dq_oe"}, 32'(mem_dq_oe), 0);
        chk({tag, " ack"}, 32'(req_ack), 0);
    endtask

    // Entered and left at a falling edge. cfg_new is applied on entry,
    // cfg_mid is applied in window cycle 1 (R10).
    task automatic do_access(bit wr, logic [14:0] a, logic [15:0] d, logic [1:0] m,
                             logic [15:0] cfg_new, logic [15:0] cfg_mid);
        int len, rec, p, cur, j;
        logic [15:0] exp_rd;
        cfg_word  = cfg_new;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_mask  = m;
        len = wr ? ref_delay(int'(cfg_new[11:8])) + 1 : ref_delay(int'(cfg_new[7:4])) + 2;
        rec = 2 * int'(cfg_new[14:12]) + 1;
        p = (cyc + 1 > earliest) ? cyc + 1 : earliest;
        exp_rd = {1'b0, a} ^ 16'hC35A;
        do begin
            @(negedge clk);
            cur = cyc;
            if (cur < p) begin
                check_quiet("R8 R9 wait");
                chk("R5 held rdata", 32'(rsp_rdata), 32'(last_rd));
            end else begin
                j = cur - p;
                if (j == 1) cfg_word = cfg_mid;
                chk("R3 R4 cs_n", 32'(mem_cs_n), 0);
                chk("R3 R4 oe_n", 32'(mem_oe_n), 32'(wr));
                chk("R3 R4 we_n", 32'(mem_we_n), 32'(!wr));
                chk("R11 addr", 32'(mem_addr), 32'(a));
                chk("R7 ub_n", 32'(mem_ub_n), 32'(!m[1]));
                chk("R7 lb_n", 32'(mem_lb_n), 32'(!m[0]));
                chk("R6 dq_oe", 32'(mem_dq_oe), 32'(wr));
                if (wr) chk("R6 dq_out", 32'(mem_dq_out), 32'(d));
                chk("R5 ack", 32'(req_ack), 32'(j == len - 1));
                if (!wr && j == len - 1) chk("R5 rdata", 32'(rsp_rdata), 32'(exp_rd));
            end
        end while (cur < p + len - 1);
        if (!wr) last_rd = exp_rd;
        req_valid = 1'b0;
        earliest = p + len + rec;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_quiet("R8 idle");
            chk("R5 held rdata", 32'(rsp_rdata), 32'(last_rd));
        end
    endtask

    bit done = 1'b0;

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_quiet("R1 reset");
        rst = 1'b0;
        earliest = cyc + 1;
        @(negedge clk);
        check_quiet("R1 after reset");

        // Short read and write, back to back, no recovery margin (R3 R4 R8)
        do_access(0, 15'h1234, 16'h0, 2'b11, mk_cfg(0, 0, 0, 4'h0), mk_cfg(0, 0, 0, 4'h0));
        do_access(1, 15'h0ABC, 16'hBEEF, 2'b01, mk_cfg(0, 0, 0, 4'h0), mk_cfg(0, 0, 0, 4'h0));
        do_access(1, 15'h7FFF, 16'h1357, 2'b10, mk_cfg(3, 5, 1, 4'h9), mk_cfg(3, 5, 1, 4'h9));

        // Non-linear read decode, codes 11..15 (R2 R3)
        for (int c = 11; c <= 15; c++)
            do_access(0, 15'(c * 301), 16'h0, 2'b11, mk_cfg(c, 2, 2, 4'hF), mk_cfg(c, 2, 2, 4'hF));

        // Non-linear write decode (R2 R4 R6 R7)
        for (int c = 10; c <= 15; c++)
            do_access(1, 15'(c * 77), 16'(c * 4099), 2'(c), mk_cfg(1, c, 0, 4'h5), mk_cfg(1, c, 0, 4'h5));

        // Long recovery, then config with no recovery arriving during it (R8 R10)
        do_access(0, 15'h2222, 16'h0, 2'b11, mk_cfg(4, 4, 7, 4'h0), mk_cfg(4, 4, 7, 4'h0));
        do_access(1, 15'h3333, 16'hA5A5, 2'b11, mk_cfg(4, 4, 0, 4'h0), mk_cfg(4, 4, 0, 4'h0));

        // Config changed inside the window (R10)
        do_access(0, 15'h4444, 16'h0, 2'b11, mk_cfg(15, 1, 3, 4'h0), mk_cfg(0, 0, 7, 4'h0));
        do_access(1, 15'h5555, 16'hC0DE, 2'b11, mk_cfg(0, 14, 2, 4'h0), mk_cfg(0, 0, 0, 4'h0));

        // Request from idle after a quiet stretch (R9 R5 hold)
        idle(25);
        do_access(0, 15'h0001, 16'h0, 2'b10, mk_cfg(12, 0, 1, 4'h3), mk_cfg(12, 0, 1, 4'h3));
        idle(8);
        do_access(1, 15'h6000, 16'h0FF0, 2'b00, mk_cfg(0, 7, 5, 4'h0), mk_cfg(0, 7, 5, 4'h0));
        idle(15);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule